// File: doc/BRIEF.md
# Windowed Address Translation Table

The block holds a small table of address windows. Each window maps a range of 64-bit incoming bus addresses onto a target interface. Software programs each window through five 32-bit registers, using a simple write strobe that carries a window index and a field selector. Each cycle the block compares the presented address with every enabled window. The first window that contains the address supplies a new base, and the offset within the window passes through unchanged. The block also reports the target-interface ID and the index of the window that hit.

A window's size is a power of two, from 2 bytes up to the whole 64-bit space. It is set by a 6-bit code that sits in the same register as the enable bit and the low part of the base, which is aligned to 4 KiB. By default the lookup result is registered, so it appears one clock after the address. The bus protocol around the lookup is handled elsewhere.

Top module: `xlat_window_table`

## Requirements
- R1: After a synchronous reset every window is disabled and its registers are zero, so every lookup misses. The registered outputs reset to out_miss=1, with address, ID and window index all zero.
- R2: A window takes part in matching only while bit 0 of its source-parameter register (field select 0) is 1. Clearing that bit makes addresses inside the window miss.
- R3: Bits 6:1 of the source-parameter register hold a size code c. The window covers 2^(c+1) bytes: every address from base to base+2^(c+1)-1 hits, and the addresses just below and just above that range miss.
- R4: The window base is {source-upper register, source-parameter bits 31:12, 12'h000}. Bits 11:7 of the source-parameter register have no effect on matching.
- R5: The source-upper register (field select 1) supplies address bits 63:32 of the base. An address whose upper bits differ misses.
- R6: On a hit the output address takes the bits at and above the window size from the translated base {translated-high (select 3), translated-low (select 2)}. It keeps the offset bits below the window size from the input address.
- R7: When several enabled windows contain the address, the window with the lowest index wins, and out_win reports that index.
- R8: On a miss out_miss is 1, and out_addr and out_tid are both 0.
- R9: out_tid is the low TID_W bits of the target-parameter register (field select 4). For example, 4 selects the first AXI4 master, 0 selects the transmit/receive path and 1 selects configuration space.
- R10: A write whose window index is NWIN or more, or whose field select is 5 to 7, changes no register.
- R11: With REG_LOOKUP=1 the result for an address appears one clock after that address is presented. Until that clock edge the outputs keep the previous result.
- R12: A register write takes effect for lookups made from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Window index of the write |
| wr_sel | input | 3 | Field select: 0 src param, 1 src upper, 2 xlat low, 3 xlat high, 4 target param |
| wr_data | input | 32 | Write data |
| lk_addr | input | 64 | Address to translate |
| out_miss | output | 1 | No enabled window contains the address |
| out_win | output | WIN_W | Index of the winning window |
| out_addr | output | 64 | Translated address |
| out_tid | output | TID_W | Target-interface ID of the winning window |

## Verification
The bench probes the first and last byte of a 4 KiB window and the addresses just past each end. An off-by-one in the size decode would extend the window or cut it short. It sets bits 11:7 of a source-parameter register to ones; a design that matched on those bits would lose the window. Several windows overlap, so reversed priority would report the higher index. Writes are sent to index 8 and to an unused field select; a design that truncated the index or decoded the selector loosely would disable window 0. One check looks at the outputs before the capturing edge, which catches a lookup that is combinational or one cycle late.

// File: rtl/xlat_window_table.sv
module xlat_window_table #(
  parameter int NWIN       = 8,
  parameter int TID_W      = 4,
  parameter bit REG_LOOKUP = 1'b1,
  localparam int IDX_W = $clog2(NWIN) + 1,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_sel,
  input  logic [31:0]      wr_data,
  input  logic [63:0]      lk_addr,
  output logic             out_miss,
  output logic [WIN_W-1:0] out_win,
  output logic [63:0]      out_addr,
  output logic [TID_W-1:0] out_tid
);

  logic [NWIN-1:0][31:0] sp_q, su_q, tl_q, th_q, tp_q;
  logic [NWIN-1:0]       hit;
  logic [63:0]           xl [NWIN];

  wire idx_ok = wr_idx < IDX_W'(NWIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      su_q <= '0;
      tl_q <= '0;
      th_q <= '0;
      tp_q <= '0;
    end else if (wr_en && idx_ok) begin
      case (wr_sel)
        3'd0: sp_q[wr_idx[WIN_W-1:0]] <= wr_data;
        3'd1: su_q[wr_idx[WIN_W-1:0]] <= wr_data;
        3'd2: tl_q[wr_idx[WIN_W-1:0]] <= wr_data;
        3'd3: th_q[wr_idx[WIN_W-1:0]] <= wr_data;
        3'd4: tp_q[wr_idx[WIN_W-1:0]] <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    wire [5:0]  code = sp_q[g][6:1];
    wire [63:0] offm = (code == 6'd63) ? '1
                     : ((64'd1 << ({1'b0, code} + 7'd1)) - 64'd1);
    wire [63:0] base = {su_q[g], sp_q[g][31:12], 12'h000};
    wire [63:0] trsl = {th_q[g], tl_q[g]};
    assign hit[g] = sp_q[g][0] && ((lk_addr & ~offm) == (base & ~offm));
    assign xl[g]  = (trsl & ~offm) | (lk_addr & offm);
  end

  logic [WIN_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--)
      if (hit[i]) sel = WIN_W'(i);
  end

  wire             nx_miss = ~|hit;
  wire [63:0]      nx_addr = nx_miss ? 64'd0 : xl[sel];
  wire [TID_W-1:0] nx_tid  = nx_miss ? '0 : tp_q[sel][TID_W-1:0];
  wire [WIN_W-1:0] nx_win  = nx_miss ? '0 : sel;

  if (REG_LOOKUP) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_miss <= 1'b1;
        out_win  <= '0;
        out_addr <= '0;
        out_tid  <= '0;
      end else begin
        out_miss <= nx_miss;
        out_win  <= nx_win;
        out_addr <= nx_addr;
        out_tid  <= nx_tid;
      end
    end

    a_r1_reset_miss: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> out_miss);

    a_r2_hit_enabled: assert property (@(posedge clk) disable iff (rst)
      !out_miss |-> $past(sp_q[out_win][0]));

    a_r6_low_bit_kept: assert property (@(posedge clk) disable iff (rst)
      !out_miss |-> out_addr[0] == $past(lk_addr[0]));

    a_r10_bad_write_ignored: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (!idx_ok || wr_sel > 3'd4)) |=>
        $stable(sp_q) && $stable(su_q) && $stable(tl_q) && $stable(th_q) && $stable(tp_q));
  end else begin : g_comb
    assign out_miss = nx_miss;
    assign out_win  = nx_win;
    assign out_addr = nx_addr;
    assign out_tid  = nx_tid;
  end

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
    out_miss |-> (out_addr == 64'd0 && out_tid == '0));

endmodule

// File: tb/xlat_window_table_tb_top.sv
module xlat_window_table_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] lk_addr = '0;
  logic        out_miss;
  logic [2:0]  out_win;
  logic [63:0] out_addr;
  logic [3:0]  out_tid;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_window_table dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_data(wr_data), .lk_addr(lk_addr), .out_miss(out_miss), .out_win(out_win),
    .out_addr(out_addr), .out_tid(out_tid)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(logic [3:0] idx, logic [31:0] sp, logic [31:0] su,
                      logic [31:0] tl, logic [31:0] th, logic [31:0] tp);
    wr(idx, 3'd0, sp); wr(idx, 3'd1, su); wr(idx, 3'd2, tl);
    wr(idx, 3'd3, th); wr(idx, 3'd4, tp);
  endtask

  task automatic look(logic [63:0] a);
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
  endtask

  task automatic expect_hit(string req, logic [63:0] a, logic [63:0] xa,
                            logic [2:0] w, logic [3:0] t);
    look(a);
    chk(req, {63'd0, out_miss}, 64'd0);
    chk(req, out_addr, xa);
    chk(req, {61'd0, out_win}, {61'd0, w});
    chk(req, {60'd0, out_tid}, {60'd0, t});
  endtask

  task automatic expect_miss(string req, logic [63:0] a);
    look(a);
    chk(req, {63'd0, out_miss}, 64'd1);
    chk(req, out_addr, 64'd0);
    chk(req, {60'd0, out_tid}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", {63'd0, out_miss}, 64'd1);
    chk("R1", out_addr, 64'd0);
    expect_miss("R1", 64'h0000_0000_8000_0000);
    expect_miss("R1", 64'h0);
  endtask

  task automatic t_noncoherent_pair;
    prog(4'd0, 32'h8000_003B, 32'h0, 32'h0, 32'h0, 32'h4);
    expect_hit("R6_R9", 64'h8000_1234, 64'h1234, 3'd0, 4'd4);
    expect_hit("R3", 64'hBFFF_FFFF, 64'h3FFF_FFFF, 3'd0, 4'd4);
    expect_miss("R3", 64'hC000_0000);
    expect_miss("R5", 64'h1_8000_0000);
    prog(4'd1, 32'hC000_003B, 32'h0, 32'h4000_0000, 32'h0, 32'h4);
    expect_hit("R12", 64'hC000_0010, 64'h4000_0010, 3'd1, 4'd4);
  endtask

  task automatic t_small_window;
    prog(4'd2, 32'h0010_0F97, 32'h10, 32'h1234_5000, 32'hAB, 32'h1);
    expect_hit("R4_R5", 64'h10_0010_0ABC, 64'hAB_1234_5ABC, 3'd2, 4'd1);
    expect_hit("R3", 64'h10_0010_0000, 64'hAB_1234_5000, 3'd2, 4'd1);
    expect_hit("R3", 64'h10_0010_0FFF, 64'hAB_1234_5FFF, 3'd2, 4'd1);
    expect_miss("R3", 64'h10_0010_1000);
    expect_miss("R3", 64'h10_000F_FFFF);
  endtask

  task automatic t_enable;
    wr(4'd0, 3'd0, 32'h8000_003A);
    expect_miss("R2", 64'h8000_1234);
    wr(4'd0, 3'd0, 32'h8000_003B);
    expect_hit("R2", 64'h8000_1234, 64'h1234, 3'd0, 4'd4);
  endtask

  task automatic t_priority;
    prog(4'd3, 32'h0000_003F, 32'h0, 32'h0, 32'h2, 32'h0);
    expect_hit("R7", 64'h8000_0010, 64'h10, 3'd0, 4'd4);
    expect_hit("R7", 64'hC000_0010, 64'h4000_0010, 3'd1, 4'd4);
    expect_hit("R7_R9", 64'h0000_0010, 64'h2_0000_0010, 3'd3, 4'd0);
  endtask

  task automatic t_bad_writes;
    wr(4'd8, 3'd0, 32'h0);
    wr(4'd9, 3'd2, 32'hFFFF_F000);
    wr(4'd0, 3'd5, 32'h0);
    wr(4'd0, 3'd7, 32'h0);
    expect_hit("R10", 64'h8000_0010, 64'h10, 3'd0, 4'd4);
    expect_hit("R10", 64'hC000_0020, 64'h4000_0020, 3'd1, 4'd4);
  endtask

  task automatic t_latency;
    expect_hit("R11", 64'h8000_0040, 64'h40, 3'd0, 4'd4);
    @(negedge clk);
    lk_addr = 64'h0000_0040;
    #5;
    chk("R11", {61'd0, out_win}, 64'd0);
    chk("R11", out_addr, 64'h40);
    @(negedge clk);
    chk("R11", {61'd0, out_win}, 64'd3);
    chk("R11", out_addr, 64'h2_0000_0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_noncoherent_pair();
    t_small_window();
    t_enable();
    t_priority();
    t_bad_writes();
    t_latency();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule